// File: doc/BRIEF.md
# Bus-Master IDE DMA Register Window

This block decodes a small I/O window that holds the bus-master DMA control registers for a set of IDE channels (two by default). Each channel owns an 8-byte slice of the window. The lower half of the slice is a byte-addressed command and status area. The upper half is a 4-byte port that holds the physical address of the descriptor table. A host access presents an offset, a size of 1, 2 or 4 bytes and, for writes, a strobe and data. Read data is combinational on the offset and size. Writes take effect at the next rising clock edge.

The command/status area is strictly byte-wide. A wider read returns all ones for the access width, and a wider write is dropped. Inside a byte access, only byte 0 (command) and byte 2 (status) hold registers. Bytes 1 and 3 read as 0xFF and ignore writes. The descriptor-table port accepts any access width at any byte lane. The low two address bits are always stored as zero.

Per-channel done and error event inputs come from the DMA engine. They update the status flags and end the active state. The command, status and table-address registers of every channel appear as flat output buses for that engine. Descriptor fetching and data movement belong to the engine and are outside this block.

Top module: `bmdma_window`

## Requirements
- R1: After reset, every command, status and table-address register reads as zero, both through the window and at the output buses.
- R2: A read of width 2 or 4 anywhere in a command/status area (slice byte 0..3) returns 0x0000FFFF or 0xFFFFFFFF respectively.
- R3: A write of width 2 or 4 to a command/status area changes neither the command nor the status register.
- R4: A 1-byte read at slice byte 0 returns the command register and one at slice byte 2 returns the status register. Slice bytes 1 and 3 read 0xFF, and byte writes to them change nothing.
- R5: The command register stores only bit 0 (start) and bit 3 (direction). All other command bits read as zero.
- R6: A command write that takes bit 0 from 0 to 1 sets status bit 0 (active). A command write that leaves bit 0 at 1 does not set it. A done or error event clears status bit 0, but a start in the same cycle wins and leaves it set.
- R7: A done event sets status bit 2 (interrupt). An error event sets status bits 1 (error) and 2.
- R8: In a status byte write, ones in bits 1 and 2 clear those bits, and bits 5 and 6 take the written value. Bit 0 is not writable. The other bits read zero. An event that sets a flag in the same cycle as a clear of that flag leaves the flag set.
- R9: The table port (slice bytes 4..7) takes 1-, 2- and 4-byte accesses. A write updates the covered byte lanes from the low bytes of the write data. A read returns the stored value shifted down by the starting lane and masked to the access width. Address bits 1:0 always read zero.
- R10: Channel i's command/status area starts at window offset 8*i and its table port at 8*i+4. Accesses to one channel leave the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_we | input | 1 | Write strobe for the current access |
| acc_off | input | 4 | Byte offset inside the window (log2 of 8*NUM_CH) |
| acc_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| acc_wdata | input | 32 | Write data, least significant byte first |
| acc_rdata | output | 32 | Read data for the current offset and width |
| evt_done | input | 2 | Per-channel transfer-done event, one cycle |
| evt_err | input | 2 | Per-channel transfer-error event, one cycle |
| ch_cmd | output | 16 | Command registers, 8 bits per channel |
| ch_status | output | 16 | Status registers, 8 bits per channel |
| ch_table | output | 64 | Descriptor-table addresses, 32 bits per channel |

## Verification
The bench targets the width rule of the command/status area. It uses wide reads and writes at registered and pad bytes. A decoder that ignored the access width would return register contents instead of all ones, or would clear the command register on a 16-bit write of zero. Pad-byte writes of zero are chosen so that a decoder folding byte 1 onto command or byte 3 onto status would visibly wipe those registers. The status priorities are hit with an event and a write in the same cycle, and a repeated start write is sent while start is already set. A wrong priority shows up as a cleared interrupt flag or a dropped active bit, and level-triggered start logic shows up as a spurious active bit. Partial table-port writes at lanes 0 and 2, and reads at lanes 1 and 2, expose lane-shift errors and a missing alignment mask.

// File: rtl/bmdma_pkg.sv
`timescale 1ns/1ps
package bmdma_pkg;

  localparam logic [7:0] CMD_KEEP   = 8'h09;
  localparam logic [7:0] STAT_W1C   = 8'h06;
  localparam logic [7:0] STAT_PLAIN = 8'h60;
  localparam int         BIT_ACTIVE = 0;
  localparam int         BIT_ERROR  = 1;
  localparam int         BIT_IRQ    = 2;

  typedef enum logic [1:0] {
    RG_CMD  = 2'd0,
    RG_STAT = 2'd1,
    RG_PAD  = 2'd2,
    RG_TAB  = 2'd3
  } rgn_e;

  // All-ones value of the access width
  function automatic logic [31:0] size_ones(input logic [2:0] sz);
    case (sz)
      3'd1:    size_ones = 32'h0000_00FF;
      3'd2:    size_ones = 32'h0000_FFFF;
      default: size_ones = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Byte lanes of a 4-byte port touched by an access starting at lane off
  function automatic logic [3:0] lane_enables(input logic [1:0] off,
                                              input logic [2:0] sz);
    logic [3:0] base;
    logic [6:0] shifted;
    case (sz)
      3'd1:    base = 4'b0001;
      3'd2:    base = 4'b0011;
      default: base = 4'b1111;
    endcase
    shifted = {3'b000, base} << off;
    lane_enables = shifted[3:0];
  endfunction

  // Merge write data (low bytes first) into the lanes covered by the access
  function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                             input logic [31:0] wdata,
                                             input logic [1:0]  off,
                                             input logic [2:0]  sz);
    logic [3:0]  en;
    logic [31:0] moved;
    en    = lane_enables(off, sz);
    moved = wdata << {off, 3'b000};
    lane_merge = old;
    for (int k = 0; k < 4; k++) begin
      if (en[k]) lane_merge[8*k +: 8] = moved[8*k +: 8];
    end
  endfunction

  // Read of a 4-byte port at lane off with width sz
  function automatic logic [31:0] port_read(input logic [31:0] val,
                                            input logic [1:0]  off,
                                            input logic [2:0]  sz);
    logic [31:0] down;
    down = val >> {off, 3'b000};
    port_read = down & size_ones(sz);
  endfunction

endpackage

// File: rtl/bmdma_decode.sv
`timescale 1ns/1ps
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int OFF_W = $clog2(8 * NUM_CH),
  localparam int CH_W  = OFF_W - 3
) (
  input  logic              acc_we,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [2:0]        acc_size,
  output logic [CH_W-1:0]   chan_sel,
  output logic              chan_ok,
  output rgn_e              region,
  output logic [1:0]        lane,
  output logic [NUM_CH-1:0] wr_cmd,
  output logic [NUM_CH-1:0] wr_stat,
  output logic [NUM_CH-1:0] wr_tab
);

  logic is_byte;

  assign chan_sel = acc_off[OFF_W-1:3];
  assign lane     = acc_off[1:0];
  assign is_byte  = (acc_size == 3'd1);
  assign chan_ok  = ({1'b0, chan_sel} < (CH_W+1)'(NUM_CH));

  always_comb begin
    if (acc_off[2])              region = RG_TAB;
    else if (acc_off[1:0] == 2'd0) region = RG_CMD;
    else if (acc_off[1:0] == 2'd2) region = RG_STAT;
    else                         region = RG_PAD;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
    logic hit;
    assign hit        = acc_we && (chan_sel == CH_W'(i));
    assign wr_cmd[i]  = hit && is_byte && (region == RG_CMD);
    assign wr_stat[i] = hit && is_byte && (region == RG_STAT);
    assign wr_tab[i]  = hit && (region == RG_TAB);
  end

endmodule

// File: rtl/bmdma_chan.sv
`timescale 1ns/1ps
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_stat,
  input  logic        wr_tab,
  input  logic [31:0] wdata,
  input  logic [1:0]  lane,
  input  logic [2:0]  size,
  input  logic        evt_done,
  input  logic        evt_err,
  output logic [7:0]  cmd,
  output logic [7:0]  status,
  output logic [31:0] table_addr,
  output logic        start_rise
);

  logic [7:0]  cmd_next;
  logic [7:0]  stat_next;
  logic [31:0] tab_next;
  logic        stop_evt;

  assign start_rise = wr_cmd && wdata[0] && !cmd[0];
  assign stop_evt   = evt_done || evt_err;

  always_comb begin
    cmd_next = cmd;
    if (wr_cmd) cmd_next = wdata[7:0] & CMD_KEEP;
  end

  // Clears first, then sets, so a set in the same cycle wins
  always_comb begin
    stat_next = status;
    if (wr_stat) begin
      stat_next = status & ~(wdata[7:0] & STAT_W1C);
      stat_next = (stat_next & ~STAT_PLAIN) | (wdata[7:0] & STAT_PLAIN);
    end
    if (stop_evt)   stat_next[BIT_ACTIVE] = 1'b0;
    if (evt_err)    stat_next[BIT_ERROR]  = 1'b1;
    if (stop_evt)   stat_next[BIT_IRQ]    = 1'b1;
    if (start_rise) stat_next[BIT_ACTIVE] = 1'b1;
  end

  always_comb begin
    tab_next = table_addr;
    if (wr_tab) begin
      tab_next      = lane_merge(table_addr, wdata, lane, size);
      tab_next[1:0] = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd        <= '0;
      status     <= '0;
      table_addr <= '0;
    end else begin
      cmd        <= cmd_next;
      status     <= stat_next;
      table_addr <= tab_next;
    end
  end

endmodule

// File: rtl/bmdma_rdmux.sv
`timescale 1ns/1ps
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int OFF_W = $clog2(8 * NUM_CH),
  localparam int CH_W  = OFF_W - 3
) (
  input  logic [CH_W-1:0]       chan_sel,
  input  logic                  chan_ok,
  input  rgn_e                  region,
  input  logic [1:0]            lane,
  input  logic [2:0]            size,
  input  logic [8*NUM_CH-1:0]   cmd_flat,
  input  logic [8*NUM_CH-1:0]   stat_flat,
  input  logic [32*NUM_CH-1:0]  tab_flat,
  output logic [31:0]           rdata
);

  logic [7:0]  sel_cmd;
  logic [7:0]  sel_stat;
  logic [31:0] sel_tab;
  logic        narrow;

  assign narrow = (size == 3'd1);

  always_comb begin
    sel_cmd  = '0;
    sel_stat = '0;
    sel_tab  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_sel == CH_W'(i)) begin
        sel_cmd  = cmd_flat[8*i +: 8];
        sel_stat = stat_flat[8*i +: 8];
        sel_tab  = tab_flat[32*i +: 32];
      end
    end
  end

  always_comb begin
    rdata = size_ones(size);
    if (chan_ok) begin
      case (region)
        RG_CMD:  if (narrow) rdata = {24'h0, sel_cmd};
        RG_STAT: if (narrow) rdata = {24'h0, sel_stat};
        RG_TAB:  rdata = port_read(sel_tab, lane, size);
        default: rdata = size_ones(size);
      endcase
    end
  end

endmodule

// File: rtl/bmdma_window.sv
`timescale 1ns/1ps
module bmdma_window
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int OFF_W = $clog2(8 * NUM_CH),
  localparam int CH_W  = OFF_W - 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_we,
  input  logic [OFF_W-1:0]      acc_off,
  input  logic [2:0]            acc_size,
  input  logic [31:0]           acc_wdata,
  output logic [31:0]           acc_rdata,
  input  logic [NUM_CH-1:0]     evt_done,
  input  logic [NUM_CH-1:0]     evt_err,
  output logic [8*NUM_CH-1:0]   ch_cmd,
  output logic [8*NUM_CH-1:0]   ch_status,
  output logic [32*NUM_CH-1:0]  ch_table
);

  logic [CH_W-1:0]   chan_sel;
  logic              chan_ok;
  rgn_e              region;
  logic [1:0]        lane;
  logic [NUM_CH-1:0] wr_cmd;
  logic [NUM_CH-1:0] wr_stat;
  logic [NUM_CH-1:0] wr_tab;
  logic [NUM_CH-1:0] start_rise;

  bmdma_decode #(.NUM_CH(NUM_CH)) u_dec (
    .acc_we   (acc_we),
    .acc_off  (acc_off),
    .acc_size (acc_size),
    .chan_sel (chan_sel),
    .chan_ok  (chan_ok),
    .region   (region),
    .lane     (lane),
    .wr_cmd   (wr_cmd),
    .wr_stat  (wr_stat),
    .wr_tab   (wr_tab)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    bmdma_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cmd     (wr_cmd[i]),
      .wr_stat    (wr_stat[i]),
      .wr_tab     (wr_tab[i]),
      .wdata      (acc_wdata),
      .lane       (lane),
      .size       (acc_size),
      .evt_done   (evt_done[i]),
      .evt_err    (evt_err[i]),
      .cmd        (ch_cmd[8*i +: 8]),
      .status     (ch_status[8*i +: 8]),
      .table_addr (ch_table[32*i +: 32]),
      .start_rise (start_rise[i])
    );
  end

  bmdma_rdmux #(.NUM_CH(NUM_CH)) u_rd (
    .chan_sel  (chan_sel),
    .chan_ok   (chan_ok),
    .region    (region),
    .lane      (lane),
    .size      (acc_size),
    .cmd_flat  (ch_cmd),
    .stat_flat (ch_status),
    .tab_flat  (ch_table),
    .rdata     (acc_rdata)
  );

endmodule

// File: rtl/bmdma_window_chk.sv
`timescale 1ns/1ps
module bmdma_window_chk #(
  parameter int NUM_CH = 2,
  localparam int OFF_W = $clog2(8 * NUM_CH),
  localparam int CH_W  = OFF_W - 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_we,
  input logic [OFF_W-1:0]     acc_off,
  input logic [2:0]           acc_size,
  input logic [31:0]          acc_rdata,
  input logic [NUM_CH-1:0]    evt_done,
  input logic [NUM_CH-1:0]    evt_err,
  input logic [8*NUM_CH-1:0]  ch_cmd,
  input logic [8*NUM_CH-1:0]  ch_status,
  input logic [NUM_CH-1:0]    start_rise
);

  assert_wide_read_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_off[2] && acc_size == 3'd4) |-> acc_rdata == 32'hFFFF_FFFF);

  assert_wide_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && !acc_off[2] && acc_size != 3'd1 && evt_done == '0 && evt_err == '0)
      |=> ($stable(ch_cmd) && $stable(ch_status)));

  assert_pad_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_off[2] && acc_size == 3'd1 && acc_off[0]) |-> acc_rdata == 32'h0000_00FF);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    assert_start_sets_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise[i] |=> ch_status[8*i]);

    assert_done_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done[i] |=> ch_status[8*i + 2]);

    assert_err_sets_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err[i] |=> (ch_status[8*i + 1] && ch_status[8*i + 2]));

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(acc_we && acc_off[OFF_W-1:3] == CH_W'(i) && !acc_off[2])
        && !evt_done[i] && !evt_err[i])
        |=> $stable(ch_status[8*i +: 8]));
  end

endmodule

bind bmdma_window bmdma_window_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_we     (acc_we),
  .acc_off    (acc_off),
  .acc_size   (acc_size),
  .acc_rdata  (acc_rdata),
  .evt_done   (evt_done),
  .evt_err    (evt_err),
  .ch_cmd     (ch_cmd),
  .ch_status  (ch_status),
  .start_rise (start_rise)
);

// File: tb/tb_bmdma_window.sv
`timescale 1ns/1ps
module tb_bmdma_window;

  typedef struct packed {
    logic        wr;
    logic [3:0]  off;
    logic [2:0]  sz;
    logic [31:0] data;   // write data, or expected read data
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  3'd1, 32'h0000_0000},  // R1 cmd0 after reset
    '{1'b1, 4'd0,  3'd1, 32'h0000_00FF},  // R5 R6 start with all bits
    '{1'b0, 4'd0,  3'd1, 32'h0000_0009},  // R5 only start and direction kept
    '{1'b0, 4'd2,  3'd1, 32'h0000_0001},  // R6 active set
    '{1'b0, 4'd0,  3'd2, 32'h0000_FFFF},  // R2 16-bit read
    '{1'b0, 4'd2,  3'd4, 32'hFFFF_FFFF},  // R2 32-bit read
    '{1'b0, 4'd1,  3'd1, 32'h0000_00FF},  // R4 pad byte 1
    '{1'b0, 4'd3,  3'd1, 32'h0000_00FF},  // R4 pad byte 3
    '{1'b1, 4'd0,  3'd2, 32'h0000_0000},  // R3 wide write to cmd
    '{1'b0, 4'd0,  3'd1, 32'h0000_0009},  // R3 cmd kept
    '{1'b1, 4'd2,  3'd1, 32'h0000_0067},  // R8 status write
    '{1'b0, 4'd2,  3'd1, 32'h0000_0061},  // R8 bits 5,6 set, bit 0 kept
    '{1'b1, 4'd2,  3'd4, 32'h0000_0000},  // R3 wide write to status
    '{1'b0, 4'd2,  3'd1, 32'h0000_0061},  // R3 status kept
    '{1'b1, 4'd1,  3'd1, 32'h0000_0000},  // R4 write pad byte 1
    '{1'b1, 4'd3,  3'd1, 32'h0000_0000},  // R4 write pad byte 3
    '{1'b0, 4'd0,  3'd1, 32'h0000_0009},  // R4 cmd untouched
    '{1'b0, 4'd2,  3'd1, 32'h0000_0061},  // R4 status untouched
    '{1'b1, 4'd4,  3'd4, 32'h1234_5677},  // R9 full table write
    '{1'b0, 4'd4,  3'd4, 32'h1234_5674},  // R9 low bits forced zero
    '{1'b0, 4'd6,  3'd2, 32'h0000_1234},  // R9 upper half read
    '{1'b0, 4'd5,  3'd1, 32'h0000_0056},  // R9 lane 1 byte read
    '{1'b1, 4'd6,  3'd2, 32'h0000_ABCD},  // R9 upper half write
    '{1'b0, 4'd4,  3'd4, 32'hABCD_5674},  // R9 merge
    '{1'b1, 4'd4,  3'd1, 32'h0000_00FF},  // R9 lane 0 byte write
    '{1'b0, 4'd4,  3'd4, 32'hABCD_56FC},  // R9 byte merge with mask
    '{1'b1, 4'd12, 3'd4, 32'h1111_1111},  // R10 channel 1 table
    '{1'b0, 4'd12, 3'd4, 32'h1111_1110},  // R10
    '{1'b0, 4'd4,  3'd4, 32'hABCD_56FC},  // R10 channel 0 table untouched
    '{1'b0, 4'd8,  3'd1, 32'h0000_0000},  // R10 channel 1 cmd still zero
    '{1'b1, 4'd8,  3'd1, 32'h0000_0008},  // R10 direction only
    '{1'b0, 4'd10, 3'd1, 32'h0000_0000},  // R6 no start, no active
    '{1'b0, 4'd8,  3'd1, 32'h0000_0008},  // R10
    '{1'b0, 4'd9,  3'd2, 32'h0000_FFFF},  // R2 wide read at pad byte
    '{1'b0, 4'd7,  3'd1, 32'h0000_00AB}   // R9 lane 3 byte read
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_we = 1'b0;
  logic [3:0]  acc_off = '0;
  logic [2:0]  acc_size = 3'd1;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [1:0]  evt_done = '0;
  logic [1:0]  evt_err = '0;
  logic [15:0] ch_cmd;
  logic [15:0] ch_status;
  logic [63:0] ch_table;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bmdma_window dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_we    (acc_we),
    .acc_off   (acc_off),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .evt_done  (evt_done),
    .evt_err   (evt_err),
    .ch_cmd    (ch_cmd),
    .ch_status (ch_status),
    .ch_table  (ch_table)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic do_write(input logic [3:0] off, input logic [2:0] sz,
                          input logic [31:0] d, input logic [1:0] dn,
                          input logic [1:0] er);
    acc_we = 1'b1; acc_off = off; acc_size = sz; acc_wdata = d;
    evt_done = dn; evt_err = er;
    @(negedge clk);
    acc_we = 1'b0; evt_done = '0; evt_err = '0;
  endtask

  task automatic pulse(input logic [1:0] dn, input logic [1:0] er);
    evt_done = dn; evt_err = er;
    @(negedge clk);
    evt_done = '0; evt_err = '0;
  endtask

  task automatic do_read(input string tag, input logic [3:0] off,
                         input logic [2:0] sz, input logic [31:0] exp);
    acc_we = 1'b0; acc_off = off; acc_size = sz;
    #1;
    check(tag, {32'h0, acc_rdata}, {32'h0, exp});
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the output buses
    check("R1 cmd bus",    {48'h0, ch_cmd},    64'h0);
    check("R1 status bus", {48'h0, ch_status}, 64'h0);
    check("R1 table bus",  ch_table,           64'h0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr)
        do_write(VECS[v].off, VECS[v].sz, VECS[v].data, 2'b00, 2'b00);
      else
        do_read($sformatf("vector %0d", v), VECS[v].off, VECS[v].sz, VECS[v].data);
    end

    // R10 per-channel output buses
    check("R10 cmd bus",    {48'h0, ch_cmd},    {48'h0, 16'h0809});
    check("R10 status bus", {48'h0, ch_status}, {48'h0, 16'h0061});
    check("R10 table bus",  ch_table,           64'h1111_1110_ABCD_56FC);

    // R7 done on channel 0 ends activity and raises interrupt; R6 active cleared
    pulse(2'b01, 2'b00);
    do_read("R7 done ch0", 4'd2, 3'd1, 32'h64);

    // R6 start write while start already set gives no new activity
    do_write(4'd0, 3'd1, 32'h09, 2'b00, 2'b00);
    do_read("R6 no rise", 4'd2, 3'd1, 32'h64);

    // R7 error on channel 1
    pulse(2'b00, 2'b10);
    do_read("R7 err ch1", 4'd10, 3'd1, 32'h06);

    // R8 write-one-to-clear of error
    do_write(4'd10, 3'd1, 32'h02, 2'b00, 2'b00);
    do_read("R8 w1c err", 4'd10, 3'd1, 32'h04);

    // R8 clear of interrupt in the same cycle as a done event: set wins
    do_write(4'd10, 3'd1, 32'h04, 2'b10, 2'b00);
    do_read("R8 set wins", 4'd10, 3'd1, 32'h04);

    // R6 start in the same cycle as an error event: active stays set
    do_write(4'd8, 3'd1, 32'h09, 2'b00, 2'b10);
    do_read("R6 start wins", 4'd10, 3'd1, 32'h07);

    // R6 stop then start again on channel 0
    do_write(4'd0, 3'd1, 32'h00, 2'b00, 2'b00);
    do_write(4'd0, 3'd1, 32'h01, 2'b00, 2'b00);
    do_read("R6 restart", 4'd2, 3'd1, 32'h65);
    do_read("R5 start only", 4'd0, 3'd1, 32'h01);

    // R1 reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 cmd after reset",    {48'h0, ch_cmd},    64'h0);
    check("R1 status after reset", {48'h0, ch_status}, 64'h0);
    check("R1 table after reset",  ch_table,           64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read("R1 table read", 4'd12, 3'd4, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule